// File: doc/BRIEF.md
# Flash Arbiter with Lifecycle Wipe Sequencer

This block decides which of two clients, a software command port and a hardware command port, may drive the shared flash back end at any moment. A client raises its request. The arbiter answers with a one-cycle grant and captures the operation code. It then holds the back-end request until the back end reports completion, and passes that completion to the owning client as a done pulse.

A lifecycle controller can ask the block to run a wipe before a return-for-analysis transition. The block never interrupts a running transaction. It lets the transaction finish, then takes ownership away from both clients for good. It erases four partition classes through a dedicated erase handshake, one class at a time, in the order data, creator, owner and isolated. Once the last erase completes, the block enters a terminal disabled state and acknowledges the lifecycle controller. It stays disabled until reset.

Top module: `flash_rma_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, every grant, done, back-end request, wipe request, acknowledge and the disable output are low.
- R2: In idle with no wipe request, a software request wins over a hardware request. The winner sees a grant high for exactly one cycle. From the next cycle, `be_req_o` stays high with the captured operation on `be_op_o` and the owner on `be_src_o` (0 = software, 1 = hardware) until the cycle in which `be_done_i` is high. In that same cycle, the owner's done output is high.
- R3: No grant is given while a transaction is in flight, even if a client keeps requesting.
- R4: A wipe request that arrives during a transaction does not cut it short. The transaction's done is still delivered, and no erase is issued before `be_done_i` has been seen.
- R5: Once `rma_req_i` is high, neither client receives any grant again.
- R6: Erases are issued one at a time on `wipe_req_o`, with `wipe_part_o` coding the partition as 0 = data, 1 = creator, 2 = owner, 3 = isolated, in that order. Each request is held with a stable code until `wipe_done_i` is high, and the next code follows in the cycle after.
- R7: In the cycle after the done of the last erase, `disable_o` is high, `wipe_req_o` is low, and `rma_ack_o` is high while `rma_req_i` is high.
- R8: While disabled, `rma_ack_o` follows `rma_req_i`. A new wipe request is acknowledged and starts no erase.
- R9: While disabled, no grant, back-end request or erase request is issued, and `be_done_i` and `wipe_done_i` have no effect. Only reset returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 1 | Software client request |
| sw_op_i | input | OP_W | Software operation code |
| sw_gnt_o | output | 1 | Software grant, one-cycle pulse |
| sw_done_o | output | 1 | Software transaction complete |
| hw_req_i | input | 1 | Hardware client request |
| hw_op_i | input | OP_W | Hardware operation code |
| hw_gnt_o | output | 1 | Hardware grant, one-cycle pulse |
| hw_done_o | output | 1 | Hardware transaction complete |
| be_req_o | output | 1 | Back-end transaction request |
| be_op_o | output | OP_W | Operation of the current transaction |
| be_src_o | output | 1 | Transaction owner, 0 software, 1 hardware |
| be_done_i | input | 1 | Back-end transaction complete |
| rma_req_i | input | 1 | Lifecycle wipe request |
| rma_ack_o | output | 1 | Lifecycle wipe acknowledge |
| wipe_req_o | output | 1 | Partition erase request |
| wipe_part_o | output | PartW | Partition being erased |
| wipe_done_i | input | 1 | Partition erase complete |
| disable_o | output | 1 | Flash access disabled |

## Verification
The checker watches the following on every cycle:
- Grants are never given together, and never given while a wipe is requested.
- Back-end and erase requests hold stable until their done.
- No erase starts before an in-flight transaction has ended.
- Disabling is terminal, comes only from a final erase done, and no acknowledge appears outside it.

The ordering of the four partitions, software winning a tie, delivery of the drained transaction's done, and recovery only through reset all depend on particular sequences. Only the directed bench scenarios show those.

// File: rtl/flash_rma_arbiter.sv
module flash_rma_arbiter #(
  parameter int OP_W = 2,
  parameter int NUM_PART = 4,
  localparam int PartW = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_req_i,
  input  logic [OP_W-1:0]  sw_op_i,
  output logic             sw_gnt_o,
  output logic             sw_done_o,
  input  logic             hw_req_i,
  input  logic [OP_W-1:0]  hw_op_i,
  output logic             hw_gnt_o,
  output logic             hw_done_o,
  output logic             be_req_o,
  output logic [OP_W-1:0]  be_op_o,
  output logic             be_src_o,
  input  logic             be_done_i,
  input  logic             rma_req_i,
  output logic             rma_ack_o,
  output logic             wipe_req_o,
  output logic [PartW-1:0] wipe_part_o,
  input  logic             wipe_done_i,
  output logic             disable_o
);

  // Idle and the terminal state are three bits apart.
  typedef enum logic [5:0] {
    ST_IDLE  = 6'b001011,
    ST_SW    = 6'b010110,
    ST_HW    = 6'b100101,
    ST_WIPE  = 6'b111000,
    ST_DEAD  = 6'b110011
  } state_e;

  localparam logic [PartW-1:0] LastPart = PartW'(NUM_PART - 1);

  state_e           state_q, state_d;
  logic [PartW-1:0] part_q, part_d;
  logic [OP_W-1:0]  op_q;
  logic             in_idle, in_sw, in_hw, in_wipe;

  assign in_idle = (state_q == ST_IDLE);
  assign in_sw   = (state_q == ST_SW);
  assign in_hw   = (state_q == ST_HW);
  assign in_wipe = (state_q == ST_WIPE);

  assign sw_gnt_o    = in_idle & ~rma_req_i & sw_req_i;
  assign hw_gnt_o    = in_idle & ~rma_req_i & ~sw_req_i & hw_req_i;
  assign be_req_o    = in_sw | in_hw;
  assign be_src_o    = in_hw;
  assign be_op_o     = op_q;
  assign sw_done_o   = in_sw & be_done_i;
  assign hw_done_o   = in_hw & be_done_i;
  assign wipe_req_o  = in_wipe;
  assign wipe_part_o = part_q;
  assign disable_o   = ~(in_idle | in_sw | in_hw | in_wipe);
  assign rma_ack_o   = disable_o & rma_req_i;

  always_comb begin
    state_d = state_q;
    part_d  = part_q;
    case (state_q)
      ST_IDLE: begin
        if (rma_req_i)     state_d = ST_WIPE;
        else if (sw_req_i) state_d = ST_SW;
        else if (hw_req_i) state_d = ST_HW;
      end
      ST_SW, ST_HW: if (be_done_i) state_d = ST_IDLE;
      ST_WIPE: begin
        if (wipe_done_i) begin
          if (part_q == LastPart) state_d = ST_DEAD;
          else                    part_d  = part_q + 1'b1;
        end
      end
      ST_DEAD: state_d = ST_DEAD;
      default: state_d = ST_DEAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      part_q  <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      part_q  <= part_d;
      if (sw_gnt_o)      op_q <= sw_op_i;
      else if (hw_gnt_o) op_q <= hw_op_i;
    end
  end

endmodule

// File: rtl/flash_rma_arbiter_chk.sv
module flash_rma_arbiter_chk #(
  parameter int NUM_PART = 4,
  parameter int OP_W = 2,
  localparam int PartW = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_gnt_o,
  input logic             hw_gnt_o,
  input logic             be_req_o,
  input logic [OP_W-1:0]  be_op_o,
  input logic             be_src_o,
  input logic             be_done_i,
  input logic             rma_req_i,
  input logic             rma_ack_o,
  input logic             wipe_req_o,
  input logic [PartW-1:0] wipe_part_o,
  input logic             wipe_done_i,
  input logic             disable_o
);

  assert_one_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_gnt_o, hw_gnt_o}));

  assert_txn_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o && !be_done_i |=> be_req_o && $stable(be_op_o) && $stable(be_src_o));

  assert_no_grant_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |-> !sw_gnt_o && !hw_gnt_o);

  assert_drain_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wipe_req_o) |-> $past(!be_req_o || be_done_i));

  assert_no_grant_rma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rma_req_i |-> !sw_gnt_o && !hw_gnt_o);

  assert_wipe_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_req_o && !wipe_done_i |=> wipe_req_o && $stable(wipe_part_o));

  assert_disable_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disable_o) |-> $past(wipe_req_o && wipe_done_i));

  assert_ack_only_dead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rma_ack_o |-> disable_o);

  assert_dead_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_o |=> disable_o);

  assert_dead_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_o |-> !be_req_o && !wipe_req_o && !sw_gnt_o && !hw_gnt_o);

endmodule

bind flash_rma_arbiter flash_rma_arbiter_chk #(.NUM_PART(NUM_PART), .OP_W(OP_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sw_gnt_o(sw_gnt_o), .hw_gnt_o(hw_gnt_o),
  .be_req_o(be_req_o), .be_op_o(be_op_o), .be_src_o(be_src_o), .be_done_i(be_done_i),
  .rma_req_i(rma_req_i), .rma_ack_o(rma_ack_o), .wipe_req_o(wipe_req_o),
  .wipe_part_o(wipe_part_o), .wipe_done_i(wipe_done_i), .disable_o(disable_o)
);

// File: tb/flash_rma_arbiter_tb_top.sv
`timescale 1ns/1ps
module flash_rma_arbiter_tb_top;
  localparam int OP_W = 2;
  localparam int NUM_PART = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_req = 0, hw_req = 0, be_done = 0, rma_req = 0, wipe_done = 0;
  logic [OP_W-1:0] sw_op = '0, hw_op = '0;
  logic sw_gnt, sw_done, hw_gnt, hw_done, be_req, be_src, rma_ack, wipe_req, dis;
  logic [OP_W-1:0] be_op;
  logic [PW-1:0] wipe_part;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_rma_arbiter #(.OP_W(OP_W), .NUM_PART(NUM_PART)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_req_i(sw_req), .sw_op_i(sw_op), .sw_gnt_o(sw_gnt), .sw_done_o(sw_done),
    .hw_req_i(hw_req), .hw_op_i(hw_op), .hw_gnt_o(hw_gnt), .hw_done_o(hw_done),
    .be_req_o(be_req), .be_op_o(be_op), .be_src_o(be_src), .be_done_i(be_done),
    .rma_req_i(rma_req), .rma_ack_o(rma_ack),
    .wipe_req_o(wipe_req), .wipe_part_o(wipe_part), .wipe_done_i(wipe_done),
    .disable_o(dis)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " sw_gnt"}, sw_gnt, 0);
    chk({tag, " hw_gnt"}, hw_gnt, 0);
    chk({tag, " be_req"}, be_req, 0);
    chk({tag, " wipe_req"}, wipe_req, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick();
    #1;
    chk_quiet("R1 in reset");
    chk("R1 disable in reset", dis, 0);
    chk("R1 ack in reset", rma_ack, 0);
    rst_n = 1;
    tick();
    #1;
    chk_quiet("R1 after reset");
    chk("R1 disable after reset", dis, 0);
    chk("R1 done after reset", sw_done | hw_done, 0);
  endtask

  task automatic t_sw_single();
    sw_req = 1; sw_op = 2'd2;
    #1;
    chk("R2 sw grant", sw_gnt, 1);
    chk("R2 no be_req yet", be_req, 0);
    tick();
    sw_req = 0;
    #1;
    chk("R2 grant is a pulse", sw_gnt, 0);
    chk("R2 be_req", be_req, 1);
    chk("R2 be_op", be_op, 2);
    chk("R2 be_src sw", be_src, 0);
    tick(); tick();
    #1;
    chk("R2 be_req held", be_req, 1);
    be_done = 1;
    #1;
    chk("R2 sw_done", sw_done, 1);
    chk("R2 hw_done quiet", hw_done, 0);
    tick();
    be_done = 0;
    #1;
    chk("R2 be_req released", be_req, 0);
  endtask

  task automatic t_priority();
    sw_req = 1; hw_req = 1; sw_op = 2'd1; hw_op = 2'd3;
    #1;
    chk("R2 sw wins", sw_gnt, 1);
    chk("R2 hw loses", hw_gnt, 0);
    tick();
    #1;
    chk("R3 no sw grant busy", sw_gnt, 0);
    chk("R3 no hw grant busy", hw_gnt, 0);
    chk("R2 src sw", be_src, 0);
    chk("R2 op sw", be_op, 1);
    be_done = 1;
    #1;
    chk("R2 sw done", sw_done, 1);
    tick();
    be_done = 0; sw_req = 0;
    #1;
    chk("R2 hw grant", hw_gnt, 1);
    tick();
    hw_req = 0;
    #1;
    chk("R2 src hw", be_src, 1);
    chk("R2 op hw", be_op, 3);
    be_done = 1;
    #1;
    chk("R2 hw done", hw_done, 1);
    chk("R2 sw done quiet", sw_done, 0);
    tick();
    be_done = 0;
  endtask

  task automatic wipe_seq(input string tag);
    for (int p = 0; p < NUM_PART; p++) begin
      #1;
      chk({tag, " R6 wipe_req"}, wipe_req, 1);
      chk({tag, " R6 wipe order"}, wipe_part, p);
      chk({tag, " R7 not yet disabled"}, dis, 0);
      tick();
      #1;
      chk({tag, " R6 code held"}, wipe_part, p);
      chk({tag, " R5 no grant in wipe"}, sw_gnt | hw_gnt, 0);
      wipe_done = 1;
      tick();
      wipe_done = 0;
    end
    #1;
    chk({tag, " R7 disabled"}, dis, 1);
    chk({tag, " R7 wipe_req low"}, wipe_req, 0);
    chk({tag, " R7 ack"}, rma_ack, 1);
  endtask

  task automatic t_rma_drain();
    sw_req = 1; sw_op = 2'd0;
    tick();
    sw_req = 0; rma_req = 1;
    #1;
    chk("R4 txn still running", be_req, 1);
    chk("R4 no erase during txn", wipe_req, 0);
    tick();
    #1;
    chk("R4 no erase before done", wipe_req, 0);
    be_done = 1;
    #1;
    chk("R4 drained done", sw_done, 1);
    tick();
    be_done = 0; sw_req = 1;
    #1;
    chk("R5 no sw grant after rma", sw_gnt, 0);
    tick();
    wipe_seq("drain");
    chk_quiet("R9 after wipe");
  endtask

  task automatic t_dead();
    rma_req = 0;
    #1;
    chk("R8 ack follows req low", rma_ack, 0);
    be_done = 1; wipe_done = 1; hw_req = 1;
    tick(); tick();
    #1;
    chk_quiet("R9 dead ignores inputs");
    chk("R9 still disabled", dis, 1);
    be_done = 0; wipe_done = 0; hw_req = 0;
    rma_req = 1;
    #1;
    chk("R8 re-request acked", rma_ack, 1);
    tick(); tick();
    #1;
    chk("R8 no new erase", wipe_req, 0);
    chk("R8 ack held", rma_ack, 1);
    rma_req = 0; sw_req = 0;
    tick();
  endtask

  task automatic t_rma_idle();
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
    #1;
    chk("R9 reset leaves disabled", dis, 0);
    rma_req = 1; hw_req = 1;
    #1;
    chk("R5 hw blocked by rma", hw_gnt, 0);
    tick();
    hw_req = 0;
    wipe_seq("idle");
    rma_req = 0;
    #1;
    chk("R8 ack drops", rma_ack, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sw_single();
    t_priority();
    t_rma_drain();
    t_dead();
    t_rma_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule